// File: doc/BRIEF.md
# ECC Engine Register Shell

This block is the memory-mapped register front end of a BCH error-correction engine. Software programs a session through it: the block and parity sizes go into a count register, and a control register selects the mode and strength and requests initialisation. The data port then streams payload bytes to the engine, and completion is acknowledged through an interrupt status register. The arithmetic engine lives outside the block and connects only through ports. The shell sends it a start pulse, the mode and strength, and beats of up to four bytes. It receives a done pulse with status fields, plus word writes that fill two readable windows: one holds parity, the other holds error reports.

In encode mode a session carries only the data block. In decode mode it carries the data block followed by its parity. The shell tracks how many bytes have been accepted and clips or drops any writes past the end. When the engine finishes, the shell raises a finished flag for the active mode. These flags, like the other status flags, are cleared by writing 1. An interrupt line reports any flag whose enable bit is set.

Top module: `ecc_ctrl_shell`

## Requirements
- R1: After reset the control, count, status and enable registers read 0, `irq` is low and `eng_start` is low.
- R2: A write to offset 0x000 loads control. Bit 0 is enable, bit 1 is init, bit 2 is encode (1) or decode (0), and bits 10:4 are strength. When init is written together with enable, `eng_start` is high for exactly the one cycle after the write. The init bit reads back as 0 from the following cycle onward.
- R3: Writing 1 to a bit at offset 0x008 clears the matching control bit. Clearing bit 0 disables the shell: data-port writes produce no beat and `eng_done` leaves the status register unchanged.
- R4: Offset 0x00C holds the block size in bytes in bits 10:0 and the parity size in bytes in bits 22:16. All other bits read 0.
- R5: A write to offset 0x010 with `bus_byte`=0 supplies the four bytes of `bus_wdata`, least significant first. With `bus_byte`=1 it supplies the single byte `bus_wdata[7:0]`. The beat appears on `eng_beat_*` one cycle after the write, and unused byte lanes read 0.
- R6: A session expects the block size in bytes in encode mode, or the block size plus the parity size in decode mode. A write that crosses this total is clipped to the remaining bytes, and writes after the total is reached produce no beat. Writing init restarts the count at zero.
- R7: On `eng_done` while enabled, status bit 2 (encode) or bit 3 (decode) is set for the current mode. Bit 1 takes `eng_uncor`, bit 0 takes `eng_err`, bits 30:24 take `eng_err_cnt` and bits 22:16 take `eng_tot_cnt`.
- R8: Writing 1 to any of status bits 3:0 at offset 0x184 clears that bit, and writing 0 leaves it unchanged. A flag set by `eng_done` in the same cycle as a clear wins.
- R9: Writing 1 to bits 3:0 at offset 0x188 sets interrupt enable bits, and writing 1 at offset 0x18C clears them. The enable bits read back at offset 0x190.
- R10: `irq` is high exactly when some status bit 3:0 and its enable bit are both 1.
- R11: A parity word written by the engine at index i reads at 0x014+4i. An error report word at index i reads at 0x084+4i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_byte | input | 1 | Data-port write carries one byte instead of four |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | Session start pulse to the engine |
| eng_encode | output | 1 | Session mode, 1 = encode |
| eng_strength | output | 7 | Correction strength |
| eng_beat_valid | output | 1 | Data beat valid |
| eng_beat_data | output | 32 | Beat bytes, first byte in bits 7:0 |
| eng_beat_nbytes | output | 3 | Number of valid bytes in the beat, 1 to 4 |
| eng_done | input | 1 | Engine finished the session |
| eng_uncor | input | 1 | Engine found uncorrectable errors |
| eng_err | input | 1 | Engine found errors |
| eng_err_cnt | input | 7 | Reported error count |
| eng_tot_cnt | input | 7 | Total error count |
| eng_par_we | input | 1 | Parity word write |
| eng_par_idx | input | $clog2(PAR_WORDS) | Parity word index |
| eng_par_word | input | 32 | Parity word |
| eng_rep_we | input | 1 | Error report word write |
| eng_rep_idx | input | $clog2(REP_WORDS) | Error report index |
| eng_rep_word | input | 32 | Error report word |

## Verification
The scoreboard predicts every beat from the write size and the remaining byte budget. A shell that ignored the budget would send an extra beat, and one that did not clip would report four bytes where one or two remain. Both show up as a mismatch or as a beat with no expected entry. The bench restarts a session with init partway through, so a byte count that is not reset gives a short beat. It also raises done in the same cycle as a clearing write, so a shell that gives priority to the clear loses the decode flag. Finally, it disables the shell through the clear alias and then writes data and signals done, which exposes a shell that keeps accepting stimulus while disabled.

// File: rtl/ecc_shell_pkg.sv
package ecc_shell_pkg;

   localparam int STR_W = 7;
   localparam int CNT_W = 7;

   localparam logic [11:0] OFS_CTRL = 12'h000;
   localparam logic [11:0] OFS_CCLR = 12'h008;
   localparam logic [11:0] OFS_CNT  = 12'h00C;
   localparam logic [11:0] OFS_DATA = 12'h010;
   localparam logic [11:0] OFS_PAR  = 12'h014;
   localparam logic [11:0] OFS_REP  = 12'h084;
   localparam logic [11:0] OFS_STAT = 12'h184;
   localparam logic [11:0] OFS_IES  = 12'h188;
   localparam logic [11:0] OFS_IEC  = 12'h18C;
   localparam logic [11:0] OFS_IE   = 12'h190;

   localparam int FL_ERR   = 0;
   localparam int FL_UNCOR = 1;
   localparam int FL_ENC   = 2;
   localparam int FL_DEC   = 3;
   localparam int FL_N     = 4;

   typedef struct packed {
      logic [STR_W-1:0] strength;
      logic             enc;
      logic             init;
      logic             en;
   } ctrl_t;

endpackage

// File: rtl/ecc_shell_window.sv
module ecc_shell_window #(
   parameter int DEPTH = 28,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [31:0]      wword,
   input  logic [7:0]       ridx,
   output logic [31:0]      rword
);

   logic [31:0] mem_q [DEPTH];

   initial begin : p_param_chk
      assert (DEPTH >= 1 && DEPTH <= 256) else $fatal(1, "window depth out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we && (32'(widx) < DEPTH)) begin
         mem_q[widx] <= wword;
      end
   end

   always_comb begin
      rword = '0;
      if (32'(ridx) < DEPTH) rword = mem_q[ridx[IDX_W-1:0]];
   end

endmodule

// File: rtl/ecc_shell_stream.sv
module ecc_shell_stream #(
   parameter int BLK_W = 11,
   parameter int PAR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             enable,
   input  logic             encode,
   input  logic [BLK_W-1:0] blk_size,
   input  logic [PAR_W-1:0] par_size,
   input  logic             wr,
   input  logic             wr_byte,
   input  logic [31:0]      wdata,
   output logic             beat_valid,
   output logic [31:0]      beat_data,
   output logic [2:0]       beat_nbytes
);

   localparam int TOT_W = ((BLK_W > PAR_W) ? BLK_W : PAR_W) + 1;

   logic [TOT_W-1:0] cnt_q, total, room;
   logic [2:0]       req, take;
   logic [3:0]       lane_on;
   logic [31:0]      raw, packed_data;
   logic             accept;

   always_comb begin
      total = encode ? TOT_W'(blk_size) : TOT_W'(blk_size) + TOT_W'(par_size);
      room  = (cnt_q >= total) ? '0 : total - cnt_q;
      req   = wr_byte ? 3'd1 : 3'd4;
      take  = (TOT_W'(req) <= room) ? req : room[2:0];
      raw   = wr_byte ? {24'h0, wdata[7:0]} : wdata;
   end

   assign accept = wr && enable && (take != 3'd0);

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign lane_on[g] = (3'(g) < take);
      assign packed_data[8*g +: 8] = lane_on[g] ? raw[8*g +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         beat_valid  <= 1'b0;
         beat_data   <= '0;
         beat_nbytes <= '0;
      end else begin
         if (restart)     cnt_q <= '0;
         else if (accept) cnt_q <= cnt_q + TOT_W'(take);
         beat_valid <= accept;
         if (accept) begin
            beat_data   <= packed_data;
            beat_nbytes <= take;
         end
      end
   end

   a_r5_beat_size: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid |-> (beat_nbytes >= 3'd1 && beat_nbytes <= 3'd4));

   a_r6_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && room == '0) |=> !beat_valid);

   a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/ecc_shell_irq.sv
module ecc_shell_irq
   import ecc_shell_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic             encode,
   input  logic             uncor,
   input  logic             err,
   input  logic [CNT_W-1:0] err_cnt,
   input  logic [CNT_W-1:0] tot_cnt,
   input  logic             stat_wr,
   input  logic             ies_wr,
   input  logic             iec_wr,
   input  logic [FL_N-1:0]  wmask,
   output logic [FL_N-1:0]  flags,
   output logic [CNT_W-1:0] err_cnt_q,
   output logic [CNT_W-1:0] tot_cnt_q,
   output logic [FL_N-1:0]  ie,
   output logic             irq
);

   logic [FL_N-1:0] set_v, clr_v;

   always_comb begin
      set_v = '0;
      if (done) begin
         set_v[FL_ERR]   = err;
         set_v[FL_UNCOR] = uncor;
         set_v[FL_ENC]   = encode;
         set_v[FL_DEC]   = !encode;
      end
      clr_v = stat_wr ? wmask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags     <= '0;
         err_cnt_q <= '0;
         tot_cnt_q <= '0;
         ie        <= '0;
      end else begin
         flags <= (flags & ~clr_v) | set_v;
         if (done) begin
            err_cnt_q <= err_cnt;
            tot_cnt_q <= tot_cnt;
         end
         if (ies_wr)      ie <= ie | wmask;
         else if (iec_wr) ie <= ie & ~wmask;
      end
   end

   assign irq = |(flags & ie);

   a_r7_enc_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done && encode) |=> flags[FL_ENC]);

   a_r7_dec_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !encode) |=> flags[FL_DEC]);

   a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wmask[FL_ENC] && !done) |=> !flags[FL_ENC]);

   a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ie != '0));

endmodule

// File: rtl/ecc_ctrl_shell.sv
module ecc_ctrl_shell
   import ecc_shell_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int BLK_W     = 11,
   parameter int PAR_W     = 7,
   parameter int PAR_WORDS = 28,
   parameter int REP_WORDS = 64,
   parameter bit REP_WIN   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_we,
   input  logic                         bus_byte,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [31:0]                  bus_wdata,
   output logic [31:0]                  bus_rdata,
   output logic                         irq,
   output logic                         eng_start,
   output logic                         eng_encode,
   output logic [6:0]                   eng_strength,
   output logic                         eng_beat_valid,
   output logic [31:0]                  eng_beat_data,
   output logic [2:0]                   eng_beat_nbytes,
   input  logic                         eng_done,
   input  logic                         eng_uncor,
   input  logic                         eng_err,
   input  logic [6:0]                   eng_err_cnt,
   input  logic [6:0]                   eng_tot_cnt,
   input  logic                         eng_par_we,
   input  logic [$clog2(PAR_WORDS)-1:0] eng_par_idx,
   input  logic [31:0]                  eng_par_word,
   input  logic                         eng_rep_we,
   input  logic [$clog2(REP_WORDS)-1:0] eng_rep_idx,
   input  logic [31:0]                  eng_rep_word
);

   localparam int PAR_SPAN = (OFS_REP - OFS_PAR) / 4;
   localparam int REP_SPAN = (OFS_STAT - OFS_REP) / 4;

   initial begin : p_param_chk
      assert (ADDR_W >= 9 && ADDR_W <= 12) else $fatal(1, "address width must be 9..12");
      assert (BLK_W >= 1 && BLK_W <= 11) else $fatal(1, "block size field is 11 bits");
      assert (PAR_W >= 1 && PAR_W <= 7) else $fatal(1, "parity size field is 7 bits");
      assert (PAR_WORDS >= 2 && PAR_WORDS <= PAR_SPAN) else $fatal(1, "parity window too deep");
      assert (REP_WORDS >= 2 && REP_WORDS <= REP_SPAN) else $fatal(1, "report window too deep");
   end

   logic [11:0]      a12;
   logic             wr_ctrl, wr_cclr, wr_cnt, wr_data, wr_stat, wr_ies, wr_iec;
   ctrl_t            ctrl_q, ctrl_n;
   logic [BLK_W-1:0] blk_q;
   logic [PAR_W-1:0] par_q;
   logic [FL_N-1:0]  flags, ie;
   logic [CNT_W-1:0] err_cnt_q, tot_cnt_q;
   logic [11:0]      par_off, rep_off;
   logic [31:0]      par_rword, rep_rword;
   logic             in_par, in_rep;

   assign a12     = 12'(bus_addr);
   assign wr_ctrl = bus_we && (a12 == OFS_CTRL);
   assign wr_cclr = bus_we && (a12 == OFS_CCLR);
   assign wr_cnt  = bus_we && (a12 == OFS_CNT);
   assign wr_data = bus_we && (a12 == OFS_DATA);
   assign wr_stat = bus_we && (a12 == OFS_STAT);
   assign wr_ies  = bus_we && (a12 == OFS_IES);
   assign wr_iec  = bus_we && (a12 == OFS_IEC);

   // control register and its clear alias; init self-clears
   always_comb begin
      ctrl_n      = ctrl_q;
      ctrl_n.init = 1'b0;
      if (wr_ctrl) begin
         ctrl_n.en       = bus_wdata[0];
         ctrl_n.init     = bus_wdata[1];
         ctrl_n.enc      = bus_wdata[2];
         ctrl_n.strength = bus_wdata[10:4];
      end else if (wr_cclr) begin
         ctrl_n.en       = ctrl_q.en  & ~bus_wdata[0];
         ctrl_n.enc      = ctrl_q.enc & ~bus_wdata[2];
         ctrl_n.strength = ctrl_q.strength & ~bus_wdata[10:4];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         blk_q  <= '0;
         par_q  <= '0;
      end else begin
         ctrl_q <= ctrl_n;
         if (wr_cnt) begin
            blk_q <= bus_wdata[BLK_W-1:0];
            par_q <= bus_wdata[16 +: PAR_W];
         end
      end
   end

   assign eng_start    = ctrl_q.init & ctrl_q.en;
   assign eng_encode   = ctrl_q.enc;
   assign eng_strength = ctrl_q.strength;

   ecc_shell_stream #(.BLK_W(BLK_W), .PAR_W(PAR_W)) u_stream (
      .clk         (clk),
      .rst_n       (rst_n),
      .restart     (wr_ctrl && bus_wdata[1]),
      .enable      (ctrl_q.en),
      .encode      (ctrl_q.enc),
      .blk_size    (blk_q),
      .par_size    (par_q),
      .wr          (wr_data),
      .wr_byte     (bus_byte),
      .wdata       (bus_wdata),
      .beat_valid  (eng_beat_valid),
      .beat_data   (eng_beat_data),
      .beat_nbytes (eng_beat_nbytes)
   );

   ecc_shell_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (eng_done && ctrl_q.en),
      .encode    (ctrl_q.enc),
      .uncor     (eng_uncor),
      .err       (eng_err),
      .err_cnt   (eng_err_cnt),
      .tot_cnt   (eng_tot_cnt),
      .stat_wr   (wr_stat),
      .ies_wr    (wr_ies),
      .iec_wr    (wr_iec),
      .wmask     (bus_wdata[FL_N-1:0]),
      .flags     (flags),
      .err_cnt_q (err_cnt_q),
      .tot_cnt_q (tot_cnt_q),
      .ie        (ie),
      .irq       (irq)
   );

   assign par_off = a12 - OFS_PAR;
   assign rep_off = a12 - OFS_REP;
   assign in_par  = (a12 >= OFS_PAR) && (a12 < OFS_REP) && (a12[1:0] == 2'b00);
   assign in_rep  = (a12 >= OFS_REP) && (a12 < OFS_STAT) && (a12[1:0] == 2'b00);

   ecc_shell_window #(.DEPTH(PAR_WORDS)) u_par_win (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (eng_par_we),
      .widx  (eng_par_idx),
      .wword (eng_par_word),
      .ridx  (par_off[9:2]),
      .rword (par_rword)
   );

   if (REP_WIN) begin : g_rep_win
      ecc_shell_window #(.DEPTH(REP_WORDS)) u_rep_win (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (eng_rep_we),
         .widx  (eng_rep_idx),
         .wword (eng_rep_word),
         .ridx  (rep_off[9:2]),
         .rword (rep_rword)
      );
   end else begin : g_no_rep_win
      logic unused_rep;
      assign unused_rep = eng_rep_we ^ (|eng_rep_idx) ^ (|eng_rep_word) ^ (|rep_off);
      assign rep_rword  = '0;
   end

   always_comb begin
      bus_rdata = '0;
      if (a12 == OFS_CTRL) begin
         bus_rdata[0]    = ctrl_q.en;
         bus_rdata[1]    = ctrl_q.init;
         bus_rdata[2]    = ctrl_q.enc;
         bus_rdata[10:4] = ctrl_q.strength;
      end else if (a12 == OFS_CNT) begin
         bus_rdata[BLK_W-1:0]  = blk_q;
         bus_rdata[16 +: PAR_W] = par_q;
      end else if (a12 == OFS_STAT) begin
         bus_rdata[FL_N-1:0] = flags;
         bus_rdata[22:16]    = tot_cnt_q;
         bus_rdata[30:24]    = err_cnt_q;
      end else if (a12 == OFS_IE) begin
         bus_rdata[FL_N-1:0] = ie;
      end else if (in_par) begin
         bus_rdata = par_rword;
      end else if (in_rep) begin
         bus_rdata = rep_rword;
      end
   end

   a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && !wr_ctrl) |=> !eng_start);

   a_r3_clear_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cclr && bus_wdata[0]) |=> !ctrl_q.en);

   a_r3_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && !wr_stat) |=> $stable(flags));

   a_r3_no_beat_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.en && wr_data) |=> !eng_beat_valid);

endmodule

// File: tb/ecc_ctrl_shell_tb.sv
module ecc_ctrl_shell_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_byte = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, eng_start, eng_encode, eng_beat_valid;
   logic [6:0]  eng_strength;
   logic [31:0] eng_beat_data;
   logic [2:0]  eng_beat_nbytes;
   logic        eng_done = 1'b0, eng_uncor = 1'b0, eng_err = 1'b0;
   logic [6:0]  eng_err_cnt = '0, eng_tot_cnt = '0;
   logic        eng_par_we = 1'b0, eng_rep_we = 1'b0;
   logic [4:0]  eng_par_idx = '0;
   logic [5:0]  eng_rep_idx = '0;
   logic [31:0] eng_par_word = '0, eng_rep_word = '0;

   int n_chk = 0, n_fail = 0;
   bit ended = 1'b0;
   logic [34:0] exp_q [$];
   logic [31:0] rd;

   always #5 clk = ~clk;

   ecc_ctrl_shell u_dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic bw(input logic [8:0] a, input logic [31:0] d, input logic byt);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_byte = byt;
      @(negedge clk);
      bus_we = 1'b0; bus_byte = 1'b0;
   endtask

   task automatic br(input logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // driver side of the scoreboard: predicts the beat, then writes
   task automatic push_data(input logic [31:0] d, input logic byt, input int room);
      int n;
      logic [31:0] v;
      n = byt ? 1 : 4;
      if (n > room) n = room;
      v = byt ? {24'h0, d[7:0]} : d;
      for (int i = n; i < 4; i++) v[8*i +: 8] = 8'h00;
      if (n > 0) exp_q.push_back({3'(n), v});
      bw(9'h010, d, byt);
   endtask

   task automatic finish_eng(input logic u, input logic e, input logic [6:0] ec, input logic [6:0] tc);
      @(negedge clk);
      eng_done = 1'b1; eng_uncor = u; eng_err = e; eng_err_cnt = ec; eng_tot_cnt = tc;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   // monitor side of the scoreboard
   always @(negedge clk) begin
      if (rst_n && eng_beat_valid) begin
         if (exp_q.size() == 0) begin
            check("R6 unexpected beat", {29'h0, eng_beat_nbytes}, 32'h0);
         end else begin
            logic [34:0] e;
            e = exp_q.pop_front();
            check("R5 beat data", eng_beat_data, e[31:0]);
            check("R6 beat size", {29'h0, eng_beat_nbytes}, {29'h0, e[34:32]});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      br(9'h000, rd); check("R1 ctrl", rd, 32'h0);
      br(9'h184, rd); check("R1 status", rd, 32'h0);
      br(9'h190, rd); check("R1 enable", rd, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 start", {31'h0, eng_start}, 32'h0);

      // R4 count fields, stray bits dropped
      bw(9'h00C, 32'h8003_F806, 1'b0);
      br(9'h00C, rd); check("R4 count", rd, 32'h0003_0006);

      // R2 encode session, strength 5
      bw(9'h000, 32'h0000_0057, 1'b0);
      check("R2 start pulse", {31'h0, eng_start}, 32'h1);
      check("R2 mode", {31'h0, eng_encode}, 32'h1);
      check("R2 strength", {25'h0, eng_strength}, 32'h5);
      br(9'h000, rd); check("R2 init cleared", rd, 32'h0000_0055);
      check("R2 start ends", {31'h0, eng_start}, 32'h0);

      // R5 R6 encode stream of 6 bytes
      push_data(32'h4433_2211, 1'b0, 6);
      push_data(32'hFFFF_FFAB, 1'b1, 2);
      push_data(32'h8877_6655, 1'b0, 1);
      push_data(32'h1234_5678, 1'b0, 0);
      repeat (2) @(negedge clk);
      check("R6 all beats seen", 32'(exp_q.size()), 32'h0);

      // R11 windows
      @(negedge clk);
      eng_par_we = 1'b1; eng_par_idx = 5'd0; eng_par_word = 32'hDEAD_BEEF;
      @(negedge clk);
      eng_par_idx = 5'd1; eng_par_word = 32'h00C0_FFEE;
      @(negedge clk);
      eng_par_we = 1'b0;
      eng_rep_we = 1'b1; eng_rep_idx = 6'd2; eng_rep_word = 32'h1234_5678;
      @(negedge clk);
      eng_rep_we = 1'b0;
      br(9'h014, rd); check("R11 parity 0", rd, 32'hDEAD_BEEF);
      br(9'h018, rd); check("R11 parity 1", rd, 32'h00C0_FFEE);
      br(9'h08C, rd); check("R11 report 2", rd, 32'h1234_5678);

      // R7 R9 R10 R8 encode completion
      finish_eng(1'b0, 1'b0, 7'd0, 7'd0);
      br(9'h184, rd); check("R7 encode flag", rd, 32'h0000_0004);
      check("R10 masked", {31'h0, irq}, 32'h0);
      bw(9'h188, 32'h4, 1'b0);
      br(9'h190, rd); check("R9 enable set", rd, 32'h4);
      check("R10 irq on", {31'h0, irq}, 32'h1);
      bw(9'h184, 32'h4, 1'b0);
      br(9'h184, rd); check("R8 cleared", rd, 32'h0);
      check("R10 irq off", {31'h0, irq}, 32'h0);

      // R6 decode session: 6 data + 3 parity bytes
      bw(9'h000, 32'h0000_0003, 1'b0);
      check("R2 decode start", {31'h0, eng_start}, 32'h1);
      push_data(32'hA3A2_A1A0, 1'b0, 9);
      push_data(32'hB3B2_B1B0, 1'b0, 5);
      push_data(32'h0000_00C0, 1'b1, 1);
      push_data(32'h0000_00C1, 1'b1, 0);
      repeat (2) @(negedge clk);
      check("R6 decode beats", 32'(exp_q.size()), 32'h0);

      finish_eng(1'b1, 1'b1, 7'd5, 7'd9);
      br(9'h184, rd); check("R7 decode status", rd, 32'h0509_000B);
      check("R10 not enabled", {31'h0, irq}, 32'h0);
      bw(9'h188, 32'h8, 1'b0);
      bw(9'h18C, 32'h4, 1'b0);
      br(9'h190, rd); check("R9 enable clear", rd, 32'h8);
      check("R10 decode irq", {31'h0, irq}, 32'h1);
      bw(9'h184, 32'h2, 1'b0);
      br(9'h184, rd); check("R8 single clear", rd, 32'h0509_0009);
      bw(9'h184, 32'h0509_000B, 1'b0);
      br(9'h184, rd); check("R8 write back", rd, 32'h0509_0000);
      check("R10 irq drops", {31'h0, irq}, 32'h0);

      // R8 set wins over same-cycle clear
      @(negedge clk);
      eng_done = 1'b1; eng_uncor = 1'b0; eng_err = 1'b0; eng_err_cnt = '0; eng_tot_cnt = '0;
      bus_we = 1'b1; bus_addr = 9'h184; bus_wdata = 32'h8;
      @(negedge clk);
      eng_done = 1'b0; bus_we = 1'b0;
      br(9'h184, rd); check("R8 set wins", rd, 32'h0000_0008);
      bw(9'h184, 32'hF, 1'b0);

      // R3 clear alias disables the shell
      bw(9'h008, 32'h1, 1'b0);
      br(9'h000, rd); check("R3 disabled", rd, 32'h0);
      push_data(32'h5555_5555, 1'b0, 0);
      finish_eng(1'b1, 1'b1, 7'd3, 7'd3);
      br(9'h184, rd); check("R3 done ignored", rd, 32'h0);
      check("R3 no beat", 32'(exp_q.size()), 32'h0);

      // R3 clear alias drops only selected bits
      bw(9'h000, 32'h0000_0075, 1'b0);
      bw(9'h008, 32'h0000_0010, 1'b0);
      br(9'h000, rd); check("R3 partial clear", rd, 32'h0000_0065);

      // R6 init restarts the byte count (encode, 6 bytes)
      bw(9'h000, 32'h0000_0007, 1'b0);
      push_data(32'h0302_0100, 1'b0, 6);
      bw(9'h000, 32'h0000_0007, 1'b0);
      push_data(32'h1312_1110, 1'b0, 6);
      push_data(32'h2322_2120, 1'b0, 2);
      repeat (2) @(negedge clk);
      check("R6 restart beats", 32'(exp_q.size()), 32'h0);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule